// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block predicts taken branches for an instruction prefetch unit. It holds a small fully associative table whose entries pair the address of a direct branch with that branch's target. Every cycle the current fetch address is looked up. A matching entry whose direction state says "taken" steers the next fetch address to the cached target. Otherwise the prefetcher simply moves one instruction step forward.

The execute stage reports each resolved branch back through a resolve port. A report carries the branch address, the target, the actual direction, whether the branch is direct, and whether the earlier prediction was correct. From this report the block allocates new entries and updates each entry's two-bit saturating direction counter. In the same cycle it issues a corrective redirect whenever the prediction was wrong. A redirect goes to the real target when the branch was taken. When a predicted-taken branch falls through, the "unbranch" redirect goes to the next sequential address. Each entry has its own hysteresis, so a loop-closing branch that has become strongly taken stays predicted taken after a single loop exit. When the table is full, the least recently used entry is replaced.

Top module: `btb_predictor`

## Requirements
- R1: After a synchronous reset every entry is invalid, so any fetch address gives next_pc = fetch_pc + 4 and pred_taken = 0.
- R2: A fetch address that matches no valid entry gives next_pc = fetch_pc + 4 and pred_taken = 0.
- R3: A fetch address that matches a valid entry gives next_pc = the stored target and pred_taken = 1 when that entry's counter is 2 or 3. When the counter is 0 or 1 it gives fetch_pc + 4 and pred_taken = 0.
- R4: A resolve report with res_direct = 1 and res_taken = 1 whose address is not in the table allocates an entry with counter value 2 (weakly taken). A branch is therefore never predicted on its first encounter, and the table never holds two entries with the same address.
- R6: A resolve report with res_direct = 1 whose address hits an entry moves that entry's counter up by one when taken and down by one when not taken. The counter saturates at 3 and at 0.
- R7: An entry at counter 3 that resolves not taken once still predicts taken.
- R8: When res_valid = 1 and res_correct = 0, redirect_valid = 1 in the same cycle. redirect_pc is res_target if res_taken = 1, and res_pc + 4 otherwise. When res_correct = 1 or res_valid = 0, redirect_valid = 0.
- R9: When all 16 entries are valid, an allocation replaces the entry least recently touched. Both lookup hits and allocations or updates count as touches. A resolve touch in a cycle is newer than a lookup touch in the same cycle. While any entry is invalid, the lowest-numbered invalid entry is filled first.
- R10: When a resolve update and a lookup hit the same entry in one cycle, the lookup uses the contents from before the update. The update is visible from the next cycle.
- R11: A resolve report with res_direct = 0 never allocates or changes an entry, although its redirect still follows R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fetch_pc | input | 32 | Current fetch address |
| next_pc | output | 32 | Predicted next fetch address |
| pred_taken | output | 1 | Lookup hit with a taken-direction counter |
| res_valid | input | 1 | A resolve report is present |
| res_pc | input | 32 | Address of the resolved branch |
| res_target | input | 32 | Actual target of the resolved branch |
| res_taken | input | 1 | Branch was actually taken |
| res_direct | input | 1 | Target is encoded in the instruction |
| res_correct | input | 1 | Earlier prediction matched the outcome |
| redirect_valid | output | 1 | Corrective redirect requested |
| redirect_pc | output | 32 | Address for the corrective redirect |

## Verification
The assertions assume that resolve reports for one branch address always carry the same target. They also assume that inputs are stable around the rising clock edge and that reset is high from time zero. The stimulus draws its branch addresses from a fixed pool, and each pool address is tied to one invariant target. Indirect reports use addresses outside the direct pool. All inputs change only on the falling clock edge. The res_correct flag is derived from the bench's own table model, so the reports stay consistent with what the block actually predicted.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int CTR_W = 2;
  localparam logic [CTR_W-1:0] CTR_INIT = 2'b10;
  localparam logic [CTR_W-1:0] CTR_MAX  = 2'b11;
  localparam logic [CTR_W-1:0] CTR_MIN  = 2'b00;

  // Saturating direction counter step
  function automatic logic [CTR_W-1:0] ctr_step(input logic [CTR_W-1:0] c,
                                                 input logic taken);
    if (taken)
      return (c == CTR_MAX) ? c : c + 1'b1;
    else
      return (c == CTR_MIN) ? c : c - 1'b1;
  endfunction

  // Direction carried by a counter
  function automatic logic ctr_taken(input logic [CTR_W-1:0] c);
    return c[CTR_W-1];
  endfunction
endpackage

// File: rtl/btb_match.sv
module btb_match #(
  parameter int ENTRIES = 16,
  parameter int AW = 32,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic [AW-1:0]               addr,
  input  logic [ENTRIES-1:0]          valid,
  input  logic [ENTRIES-1:0][AW-1:0]  tags,
  output logic [ENTRIES-1:0]          match,
  output logic                        hit,
  output logic [IW-1:0]               idx
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid[g] && (tags[g] == addr);
  end

  assign hit = |match;

  always_comb begin
    idx = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) idx = IW'(i);
  end
endmodule

// File: rtl/btb_lru.sv
module btb_lru #(
  parameter int ENTRIES = 16,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ENTRIES-1:0] valid,
  input  logic               a_en,
  input  logic [IW-1:0]      a_idx,
  input  logic               b_en,
  input  logic [IW-1:0]      b_idx,
  output logic [IW-1:0]      victim
);
  typedef logic [ENTRIES-1:0][IW-1:0] rank_vec_t;

  rank_vec_t rank_q, rank_mid, rank_d;
  logic [ENTRIES-1:0] oldest;
  logic               any_free;
  logic [IW-1:0]      free_idx, old_idx;

  // Move entry k to rank 0, age everything that was younger than it
  function automatic rank_vec_t promote(input rank_vec_t r, input logic [IW-1:0] k);
    rank_vec_t o;
    for (int j = 0; j < ENTRIES; j++) begin
      if (IW'(j) == k)          o[j] = '0;
      else if (r[j] < r[k])     o[j] = r[j] + 1'b1;
      else                      o[j] = r[j];
    end
    return o;
  endfunction

  always_comb begin
    rank_mid = a_en ? promote(rank_q, a_idx) : rank_q;
    rank_d   = b_en ? promote(rank_mid, b_idx) : rank_mid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) rank_q[i] <= IW'(i);
    end else begin
      rank_q <= rank_d;
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_old
    assign oldest[g] = (rank_q[g] == IW'(ENTRIES - 1));
  end

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    old_idx  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
      if (oldest[i]) old_idx = IW'(i);
    end
    victim = any_free ? free_idx : old_idx;
  end

  AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1); // R9
  AST_LRU_RESOLVE_FRESH: assert property (@(posedge clk) disable iff (rst)
    b_en |=> rank_q[$past(b_idx)] == '0); // R9
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ENTRIES = 16,
  parameter int AW = 32,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] fetch_pc,
  output logic [AW-1:0] next_pc,
  output logic          pred_taken,
  input  logic          res_valid,
  input  logic [AW-1:0] res_pc,
  input  logic [AW-1:0] res_target,
  input  logic          res_taken,
  input  logic          res_direct,
  input  logic          res_correct,
  output logic          redirect_valid,
  output logic [AW-1:0] redirect_pc
);
  import btb_pkg::*;
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]                valid_q;
  logic [ENTRIES-1:0][AW-1:0]        tag_q;
  logic [ENTRIES-1:0][AW-1:0]        tgt_q;
  logic [ENTRIES-1:0][CTR_W-1:0]     ctr_q;

  // Named internal events
  logic [ENTRIES-1:0] look_match, res_match;
  logic               look_hit, res_hit;
  logic [IW-1:0]      look_idx, res_idx, victim_idx;
  logic               upd_en, alloc_en;

  function automatic logic [AW-1:0] seq_addr(input logic [AW-1:0] a);
    return a + AW'(STEP);
  endfunction

  btb_match #(.ENTRIES(ENTRIES), .AW(AW)) u_look (
    .addr(fetch_pc), .valid(valid_q), .tags(tag_q),
    .match(look_match), .hit(look_hit), .idx(look_idx));

  btb_match #(.ENTRIES(ENTRIES), .AW(AW)) u_res (
    .addr(res_pc), .valid(valid_q), .tags(tag_q),
    .match(res_match), .hit(res_hit), .idx(res_idx));

  assign upd_en   = res_valid && res_direct && res_hit;
  assign alloc_en = res_valid && res_direct && res_taken && !res_hit;

  btb_lru #(.ENTRIES(ENTRIES)) u_lru (
    .clk(clk), .rst(rst), .valid(valid_q),
    .a_en(look_hit), .a_idx(look_idx),
    .b_en(upd_en || alloc_en), .b_idx(alloc_en ? victim_idx : res_idx),
    .victim(victim_idx));

  // Prediction path
  assign pred_taken = look_hit && ctr_taken(ctr_q[look_idx]);
  assign next_pc    = pred_taken ? tgt_q[look_idx] : seq_addr(fetch_pc);

  // Corrective redirect
  assign redirect_valid = res_valid && !res_correct;
  assign redirect_pc    = res_taken ? res_target : seq_addr(res_pc);

  // Table write
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (upd_en)
        ctr_q[res_idx] <= ctr_step(ctr_q[res_idx], res_taken);
      if (alloc_en) begin
        valid_q[victim_idx] <= 1'b1;
        tag_q[victim_idx]   <= res_pc;
        tgt_q[victim_idx]   <= res_target;
        ctr_q[victim_idx]   <= CTR_INIT;
      end
    end
  end

  AST_UNIQUE_TAG: assert property (@(posedge clk) disable iff (rst)
    $onehot0(look_match)); // R4
  AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (rst)
    alloc_en |=> valid_q[$past(victim_idx)] && ctr_q[$past(victim_idx)] == CTR_INIT); // R4
  AST_CTR_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    upd_en && res_taken && ctr_q[res_idx] == CTR_MAX |=> ctr_q[$past(res_idx)] == CTR_MAX); // R6
  AST_CTR_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    upd_en && !res_taken && ctr_q[res_idx] == CTR_MIN |=> ctr_q[$past(res_idx)] == CTR_MIN); // R6
  AST_LOOP_EXIT_KEEP: assert property (@(posedge clk) disable iff (rst)
    upd_en && !res_taken && ctr_q[res_idx] == CTR_MAX |=> ctr_taken(ctr_q[$past(res_idx)])); // R7
  AST_INDIRECT_NO_ALLOC: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_direct |=> $stable(valid_q) && $stable(tag_q)); // R11
endmodule

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] fetch_pc = '0;
  logic [31:0] next_pc;
  logic        pred_taken;
  logic        res_valid = 1'b0;
  logic [31:0] res_pc = '0, res_target = '0;
  logic        res_taken = 1'b0, res_direct = 1'b0, res_correct = 1'b0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  btb_predictor dut (
    .clk(clk), .rst(rst), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_taken(pred_taken), .res_valid(res_valid), .res_pc(res_pc),
    .res_target(res_target), .res_taken(res_taken), .res_direct(res_direct),
    .res_correct(res_correct), .redirect_valid(redirect_valid),
    .redirect_pc(redirect_pc));

  // Reference table: last-use timestamps instead of ranks
  bit          m_v[N];
  logic [31:0] m_tag[N];
  logic [31:0] m_tgt[N];
  int          m_ctr[N];
  longint      m_st[N];
  longint      cyc = 0;

  function automatic int m_find(input logic [31:0] a);
    for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    int best = 0;
    for (int i = 0; i < N; i++) if (!m_v[i]) return i;
    for (int i = 1; i < N; i++) if (m_st[i] < m_st[best]) best = i;
    return best;
  endfunction

  function automatic bit m_pred(input logic [31:0] a);
    int k = m_find(a);
    return (k >= 0) && (m_ctr[k] >= 2);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [31:0] f, input bit rv, input logic [31:0] rp,
                      input logic [31:0] rt, input bit tk, input bit dr,
                      input bit cr, input string tag);
    int li, ri, vi;
    bit ept;
    logic [31:0] enext, eredir;
    @(negedge clk);
    fetch_pc = f; res_valid = rv; res_pc = rp; res_target = rt;
    res_taken = tk; res_direct = dr; res_correct = cr;
    #1;
    li = m_find(f);
    ept = (li >= 0) && (m_ctr[li] >= 2);
    enext = ept ? m_tgt[li] : f + 32'd4;
    check(next_pc == enext, {tag, " next_pc"}, next_pc, enext);
    check(pred_taken == ept, {tag, " pred_taken"}, {31'd0, pred_taken}, {31'd0, ept});
    check(redirect_valid == (rv && !cr), "R8 redirect_valid",
          {31'd0, redirect_valid}, {31'd0, rv && !cr});
    if (rv && !cr) begin
      eredir = tk ? rt : rp + 32'd4;
      check(redirect_pc == eredir, "R8 redirect_pc", redirect_pc, eredir);
    end
    @(posedge clk);
    cyc++;
    vi = m_victim();
    ri = m_find(rp);
    if (li >= 0) m_st[li] = 2 * cyc;
    if (rv && dr) begin
      if (ri >= 0) begin
        if (tk) m_ctr[ri] = (m_ctr[ri] == 3) ? 3 : m_ctr[ri] + 1;
        else    m_ctr[ri] = (m_ctr[ri] == 0) ? 0 : m_ctr[ri] - 1;
        m_st[ri] = 2 * cyc + 1;
      end else if (tk) begin
        m_v[vi] = 1'b1; m_tag[vi] = rp; m_tgt[vi] = rt;
        m_ctr[vi] = 2; m_st[vi] = 2 * cyc + 1;
      end
    end
  endtask

  task automatic resolve(input logic [31:0] f, input logic [31:0] rp,
                         input logic [31:0] rt, input bit tk, input string tag);
    step(f, 1'b1, rp, rt, tk, 1'b1, m_pred(rp) == tk, tag);
  endtask

  initial begin
    #(200000 * 8);
    total++; bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] a_pc, a_tg, b_pc;
    int unsigned r;
    a_pc = 32'h0000_0200; a_tg = 32'h0000_0800; b_pc = 32'h0000_0400;
    for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    step(32'h100, 0, 0, 0, 0, 0, 1, "R1 reset state");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R1 no entries after reset");
    // First encounter: allocate, redirect to target
    resolve(32'h100, a_pc, a_tg, 1, "R4 allocate on taken miss");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R3 R4 weakly taken hit");
    // Unbranch
    resolve(32'h300, a_pc, a_tg, 0, "R8 unbranch");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R3 R6 counter 1 not taken");
    resolve(32'h300, a_pc, a_tg, 1, "R6 up to 2");
    resolve(32'h300, a_pc, a_tg, 1, "R6 up to 3");
    resolve(32'h300, a_pc, a_tg, 1, "R6 saturate at 3");
    resolve(32'h300, a_pc, a_tg, 0, "R7 loop exit");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R7 still taken after one exit");
    resolve(32'h300, a_pc, a_tg, 0, "R6 down to 1");
    resolve(32'h300, a_pc, a_tg, 0, "R6 down to 0");
    resolve(32'h300, a_pc, a_tg, 0, "R6 saturate at 0");
    resolve(32'h300, a_pc, a_tg, 1, "R6 up from 0");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R6 low saturation gives 1");
    // Indirect branch
    step(32'h100, 1, b_pc, 32'h900, 1, 0, 0, "R11 indirect redirect");
    step(b_pc, 0, 0, 0, 0, 0, 1, "R11 indirect not cached");
    // Same-cycle update and lookup (counter is 1)
    resolve(a_pc, a_pc, a_tg, 1, "R10 lookup sees old contents");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R10 update visible next cycle");
    // Misses
    for (int i = 0; i < 8; i++)
      step(32'h7000 + 32'(i) * 4, 0, 0, 0, 0, 0, 1, "R2 miss sequential");
    // Fill past capacity
    for (int k = 0; k < 18; k++) begin
      resolve(32'h100, 32'h2000 + 32'(k) * 32'h40, 32'h9000 + 32'(k) * 16, 1, "R9 fill");
      if (k == 8) step(a_pc, 0, 0, 0, 0, 0, 1, "R9 refresh by hit");
    end
    for (int k = 0; k < 18; k++)
      step(32'h2000 + 32'(k) * 32'h40, 0, 0, 0, 0, 0, 1, "R9 after eviction");
    step(a_pc, 0, 0, 0, 0, 0, 1, "R9 refreshed entry kept");
    // Pseudo-random sweep over a pool of 20 direct branches
    r = 32'h1234_5677;
    for (int n = 0; n < 900; n++) begin
      logic [31:0] f, p, t;
      bit rv, dr, tk;
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      p = 32'h1000 + 32'((r >> 3) % 20) * 32'h40;
      t = 32'h8000 + 32'((r >> 3) % 20) * 16;
      f = ((r >> 9) & 3) != 0 ? 32'h1000 + 32'((r >> 11) % 20) * 32'h40
                              : 32'h5000 + 32'((r >> 16) & 255) * 4;
      rv = r[20];
      dr = ((r >> 21) & 7) != 0;
      tk = ((r >> 24) & 3) != 0;
      if (!dr) begin p = 32'h6000 + 32'((r >> 3) & 15) * 4; t = 32'hA000; end
      step(f, rv, p, t, tk, dr, m_pred(p) == tk, "R3 R9 sweep");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule